// File: doc/BRIEF.md
# DMA Descriptor Chain Walker

This block walks a linked list of DMA transfer descriptors in memory and hands each one, already decoded, to a separate data-moving engine. A descriptor is six words at consecutive word addresses. The current-descriptor pointer is kept in the block. The next-descriptor pointer arrives in two halves, and the walker joins them into one pointer twice the word width. Only one read to memory is outstanding at a time. A next pointer of zero ends the chain.

Software can pause the walk so that it can splice a new sub-chain into a running list. The walker samples the suspend bit at two points only: at the end of a transfer and while a descriptor is being fetched. It never samples it during a transfer.

- A suspend taken at a transfer boundary leaves the current pointer where it is. On resume, the walker re-reads only the link words of that descriptor, so it follows a pointer that software rewrote. It does not repeat the transfer.
- A suspend taken during a fetch throws away any read still in flight. On resume, the walker fetches the whole descriptor again and then executes it.

States:

| State | Meaning |
|---|---|
| IDLE | Reset state; no chain has been started. |
| FETCH | Reading descriptor words from memory. |
| ACTIVE | Descriptor handed to the engine; waiting for the transfer to finish. |
| SUSPENDED | Paused by software. |
| DONE | The chain has ended. |

Transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| start | IDLE or DONE | FETCH | Start pulse; the start address is loaded as the current pointer. |
| fetched | FETCH | ACTIVE | Last word of a full fetch arrives. |
| relink | FETCH | FETCH | Link-only re-read ends with a non-zero link; the link is loaded as the current pointer. |
| relink_end | FETCH | DONE | Link-only re-read ends with a zero link. |
| fetch_pause | FETCH | SUSPENDED | Suspend bit is high. |
| advance | ACTIVE | FETCH | Transfer done, suspend low, next pointer non-zero. |
| finish | ACTIVE | DONE | Transfer done, suspend low, next pointer zero. |
| edge_pause | ACTIVE | SUSPENDED | Transfer done with the suspend bit high. |
| resume | SUSPENDED | FETCH | Resume pulse, suspend bit low, no read outstanding. |

Top module: `dchain_walker`

## Requirements
- R1: While reset is asserted and after it is released, `walk_status` is 0 (IDLE), and both `mem_req_valid` and `desc_valid` are low.
- R2: A `ctl_start` pulse in IDLE or DONE loads `ctl_start_addr` into `cur_desc_addr` and enters FETCH (status 1). The walker then reads the words at `cur_desc_addr`+0 through +5, in the order next-low, next-high, source, destination, count, control, with at most one read outstanding. Requests are made only in FETCH. A start pulse in any other state has no effect.
- R3: After the control word arrives, the status is ACTIVE (2). `desc_valid` is high, and the source, destination, count and control fields are held stable until `xfer_done`. `desc_valid` is high only in ACTIVE.
- R4: On `xfer_done` with suspend low, the walker checks the next pointer. If it is non-zero, it becomes the current pointer and a new fetch starts. If it is zero, the status becomes DONE (4), with `desc_valid` and `mem_req_valid` low.
- R5: The next pointer is {next-high word, next-low word}, so the high word supplies the upper half of the address.
- R6: The suspend bit has no effect in ACTIVE until `xfer_done`. If `xfer_done` arrives with suspend high, the status becomes SUSPENDED (3), the current pointer is unchanged, and no reads are issued.
- R7: Suspend high in FETCH moves the walker to SUSPENDED at the next edge, with the current pointer unchanged. A read response that arrives after that is discarded.
- R8: A resume pulse is taken only in SUSPENDED, with suspend low and no read outstanding. Otherwise it has no effect.
- R9: After a boundary suspend, resume re-reads only the two link words of the current descriptor. The walker then goes to the pointer it just read, or to DONE if that pointer is zero, without presenting the finished descriptor again.
- R10: After a suspend during a fetch, resume re-reads all six words of the current descriptor and then presents it. Values written to memory while suspended are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_start | input | 1 | Start pulse |
| ctl_suspend | input | 1 | Suspend bit (level) |
| ctl_resume | input | 1 | Resume pulse |
| ctl_start_addr | input | PTR_W | First descriptor address |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | PTR_W | Read word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | WORD_W | Read data |
| desc_valid | output | 1 | Descriptor presented to the engine |
| desc_src | output | WORD_W | Source address field |
| desc_dst | output | WORD_W | Destination address field |
| desc_count | output | WORD_W | Byte count field |
| desc_ctrl | output | WORD_W | Control field |
| xfer_done | input | 1 | Engine finished the transfer |
| walk_status | output | 3 | 0 IDLE, 1 FETCH, 2 ACTIVE, 3 SUSPENDED, 4 DONE |
| cur_desc_addr | output | PTR_W | Current descriptor address |

## Verification
The bench sweeps chain lengths, memory latencies and request stalls, then goes after the cases that are easy to get wrong.

- **Wide pointer.** A chain whose second descriptor sits above the 16-bit boundary fails if the high link word is dropped: the walker would fetch a decoy descriptor instead.
- **Boundary suspend.** The walker must stay on the current descriptor. On resume, a splice must be followed, the finished descriptor must not be presented again, and exactly two link reads must be made. A design that advanced the current pointer would skip the splice. A design that re-fetched in full would present the finished descriptor twice.
- **Suspend during a fetch.** The in-flight read must be dropped. An early resume pulse, while that read is still outstanding, must be refused. On the real resume, memory contents changed while suspended must be the ones presented. A design that leaked the stale read, or resumed too early, would show old or shifted fields.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_ACTIVE = 3'd2,
        ST_SUSP   = 3'd3,
        ST_DONE   = 3'd4
    } walk_state_e;

    // word order inside a descriptor record
    localparam int unsigned W_NEXT_LO  = 0;
    localparam int unsigned W_NEXT_HI  = 1;
    localparam int unsigned W_SRC      = 2;
    localparam int unsigned W_DST      = 3;
    localparam int unsigned W_COUNT    = 4;
    localparam int unsigned W_CTRL     = 5;
    localparam int unsigned DESC_WORDS = 6;
    localparam int unsigned LINK_WORDS = 2;
    localparam int unsigned IDX_W      = $clog2(DESC_WORDS);

endpackage

// File: rtl/dchain_fetch_seq.sv
module dchain_fetch_seq
    import dchain_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PTR_W  = 2 * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_clr,
    input  logic             seq_run,
    input  logic             seq_abort,
    input  logic             link_only,
    input  logic [PTR_W-1:0] base_ptr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PTR_W-1:0] mem_req_addr,
    input  logic             mem_rsp_valid,
    output logic             rsp_pending,
    output logic             word_we,
    output logic [IDX_W-1:0] word_idx,
    output logic             fetch_last
);

    logic             pend_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;
    logic             req_fire;
    logic             rsp_fire;

    // one read in flight at most; no new request while suspending
    assign mem_req_valid = seq_run && !pend_q && !seq_abort;
    assign mem_req_addr  = base_ptr + PTR_W'(idx_q);
    assign req_fire      = mem_req_valid && mem_req_ready;
    assign rsp_fire      = mem_rsp_valid && pend_q;

    // a response is kept only while fetching and not being suspended
    assign word_we    = rsp_fire && seq_run && !seq_abort;
    assign last_idx   = link_only ? IDX_W'(LINK_WORDS - 1) : IDX_W'(DESC_WORDS - 1);
    assign fetch_last = word_we && (idx_q == last_idx);

    assign rsp_pending = pend_q;
    assign word_idx    = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (req_fire) begin
            pend_q <= 1'b1;
        end else if (rsp_fire) begin
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (seq_clr) begin
            idx_q <= '0;
        end else if (word_we) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

endmodule

// File: rtl/dchain_desc_regs.sv
module dchain_desc_regs
    import dchain_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PTR_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_we,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] word_data,
    output logic [PTR_W-1:0]  next_ptr,
    output logic [WORD_W-1:0] next_lo,
    output logic [WORD_W-1:0] fld_src,
    output logic [WORD_W-1:0] fld_dst,
    output logic [WORD_W-1:0] fld_count,
    output logic [WORD_W-1:0] fld_ctrl
);

    logic [WORD_W-1:0] word_q [DESC_WORDS];

    for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[gi] <= '0;
            end else if (word_we && (word_idx == IDX_W'(gi))) begin
                word_q[gi] <= word_data;
            end
        end
    end

    assign next_ptr  = PTR_W'({word_q[W_NEXT_HI], word_q[W_NEXT_LO]});
    assign next_lo   = word_q[W_NEXT_LO];
    assign fld_src   = word_q[W_SRC];
    assign fld_dst   = word_q[W_DST];
    assign fld_count = word_q[W_COUNT];
    assign fld_ctrl  = word_q[W_CTRL];

endmodule

// File: rtl/dchain_walk_fsm.sv
module dchain_walk_fsm
    import dchain_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PTR_W-1:0] start_addr_i,
    input  logic             suspend_i,
    input  logic             resume_i,
    input  logic             xfer_done_i,
    input  logic             fetch_last_i,
    input  logic             rsp_pending_i,
    input  logic [PTR_W-1:0] next_ptr_i,
    input  logic [PTR_W-1:0] link_target_i,
    output walk_state_e      state_o,
    output logic [PTR_W-1:0] cur_ptr_o,
    output logic             seq_clr_o,
    output logic             seq_run_o,
    output logic             desc_live_o,
    output logic             link_only_o
);

    walk_state_e      state_q, state_d;
    logic [PTR_W-1:0] cur_q;
    logic             link_q;
    logic             load_start, load_next, load_link, resume_go, set_link;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        load_start = 1'b0;
        load_next  = 1'b0;
        load_link  = 1'b0;
        resume_go  = 1'b0;
        set_link   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d    = ST_FETCH;
                    load_start = 1'b1;
                end
            end
            ST_FETCH: begin
                if (suspend_i) begin
                    state_d = ST_SUSP;
                end else if (fetch_last_i) begin
                    if (!link_q) begin
                        state_d = ST_ACTIVE;
                    end else if (link_target_i == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d   = ST_FETCH;
                        load_link = 1'b1;
                    end
                end
            end
            ST_ACTIVE: begin
                if (xfer_done_i) begin
                    if (suspend_i) begin
                        state_d  = ST_SUSP;
                        set_link = 1'b1;
                    end else if (next_ptr_i == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d   = ST_FETCH;
                        load_next = 1'b1;
                    end
                end
            end
            ST_SUSP: begin
                if (resume_i && !suspend_i && !rsp_pending_i) begin
                    state_d   = ST_FETCH;
                    resume_go = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            link_q <= 1'b0;
        end else begin
            if (load_start) begin
                cur_q <= start_addr_i;
            end else if (load_next) begin
                cur_q <= next_ptr_i;
            end else if (load_link) begin
                cur_q <= link_target_i;
            end
            if (set_link) begin
                link_q <= 1'b1;
            end else if (load_start || load_next || load_link) begin
                link_q <= 1'b0;
            end
        end
    end

    always_comb begin
        state_o     = state_q;
        cur_ptr_o   = cur_q;
        seq_clr_o   = load_start || load_next || load_link || resume_go;
        seq_run_o   = (state_q == ST_FETCH);
        desc_live_o = (state_q == ST_ACTIVE);
        link_only_o = link_q;
    end

endmodule

// File: rtl/dchain_walker.sv
module dchain_walker
    import dchain_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int PTR_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_start,
    input  logic              ctl_suspend,
    input  logic              ctl_resume,
    input  logic [PTR_W-1:0]  ctl_start_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PTR_W-1:0]  mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              desc_valid,
    output logic [WORD_W-1:0] desc_src,
    output logic [WORD_W-1:0] desc_dst,
    output logic [WORD_W-1:0] desc_count,
    output logic [WORD_W-1:0] desc_ctrl,
    input  logic              xfer_done,
    output logic [2:0]        walk_status,
    output logic [PTR_W-1:0]  cur_desc_addr
);

    walk_state_e       state;
    logic [PTR_W-1:0]  cur_ptr;
    logic [PTR_W-1:0]  next_ptr;
    logic [PTR_W-1:0]  link_target;
    logic [WORD_W-1:0] next_lo;
    logic              seq_clr, seq_run, link_only, rsp_pending;
    logic              word_we, fetch_last;
    logic [IDX_W-1:0]  word_idx;

    // on a link-only re-read the high half is still on the response bus
    assign link_target = PTR_W'({mem_rsp_data, next_lo});

    dchain_fetch_seq #(.WORD_W(WORD_W), .PTR_W(PTR_W)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .seq_clr       (seq_clr),
        .seq_run       (seq_run),
        .seq_abort     (ctl_suspend),
        .link_only     (link_only),
        .base_ptr      (cur_ptr),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_pending   (rsp_pending),
        .word_we       (word_we),
        .word_idx      (word_idx),
        .fetch_last    (fetch_last)
    );

    dchain_desc_regs #(.WORD_W(WORD_W), .PTR_W(PTR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_we   (word_we),
        .word_idx  (word_idx),
        .word_data (mem_rsp_data),
        .next_ptr  (next_ptr),
        .next_lo   (next_lo),
        .fld_src   (desc_src),
        .fld_dst   (desc_dst),
        .fld_count (desc_count),
        .fld_ctrl  (desc_ctrl)
    );

    dchain_walk_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (ctl_start),
        .start_addr_i  (ctl_start_addr),
        .suspend_i     (ctl_suspend),
        .resume_i      (ctl_resume),
        .xfer_done_i   (xfer_done),
        .fetch_last_i  (fetch_last),
        .rsp_pending_i (rsp_pending),
        .next_ptr_i    (next_ptr),
        .link_target_i (link_target),
        .state_o       (state),
        .cur_ptr_o     (cur_ptr),
        .seq_clr_o     (seq_clr),
        .seq_run_o     (seq_run),
        .desc_live_o   (desc_valid),
        .link_only_o   (link_only)
    );

    assign walk_status   = state;
    assign cur_desc_addr = cur_ptr;

endmodule

// File: rtl/dchain_walker_chk.sv
module dchain_walker_chk #(
    parameter int WORD_W = 16,
    parameter int PTR_W  = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_suspend,
    input logic              ctl_resume,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_rsp_valid,
    input logic              desc_valid,
    input logic [WORD_W-1:0] desc_src,
    input logic [WORD_W-1:0] desc_dst,
    input logic [WORD_W-1:0] desc_count,
    input logic [WORD_W-1:0] desc_ctrl,
    input logic              xfer_done,
    input logic [2:0]        walk_status,
    input logic [PTR_W-1:0]  cur_desc_addr
);

    logic [1:0] outs_q;

    // independent count of reads accepted but not yet answered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outs_q <= '0;
        end else if (mem_req_valid && mem_req_ready) begin
            outs_q <= outs_q + 2'd1;
        end else if (mem_rsp_valid && outs_q != 2'd0) begin
            outs_q <= outs_q - 2'd1;
        end
    end

    assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> outs_q == 2'd0);

    assert_req_only_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> walk_status == 3'd1);

    assert_valid_only_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> walk_status == 3'd2);

    assert_desc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !xfer_done |=> desc_valid && $stable(desc_src) && $stable(desc_dst)
                                     && $stable(desc_count) && $stable(desc_ctrl));

    assert_done_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        walk_status == 3'd4 |-> !desc_valid && !mem_req_valid);

    assert_active_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_status == 3'd2 && !xfer_done |=> walk_status == 3'd2);

    assert_edge_suspend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        walk_status == 3'd2 && xfer_done && ctl_suspend |=> walk_status == 3'd3 && $stable(cur_desc_addr));

    assert_fetch_suspend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        walk_status == 3'd1 && ctl_suspend |=> walk_status == 3'd3 && $stable(cur_desc_addr));

    assert_resume_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_status == 3'd3 && (ctl_suspend || !ctl_resume || outs_q != 2'd0) |=> walk_status == 3'd3);

endmodule

bind dchain_walker dchain_walker_chk #(.WORD_W(WORD_W), .PTR_W(PTR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_suspend   (ctl_suspend),
    .ctl_resume    (ctl_resume),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .desc_valid    (desc_valid),
    .desc_src      (desc_src),
    .desc_dst      (desc_dst),
    .desc_count    (desc_count),
    .desc_ctrl     (desc_ctrl),
    .xfer_done     (xfer_done),
    .walk_status   (walk_status),
    .cur_desc_addr (cur_desc_addr)
);

// File: tb/dchain_walker_tb_top.sv
module dchain_walker_tb_top;

    localparam int WORD_W = 16;
    localparam int PTR_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ctl_start, ctl_suspend, ctl_resume;
    logic [PTR_W-1:0]  ctl_start_addr;
    logic              mem_req_valid, mem_req_ready;
    logic [PTR_W-1:0]  mem_req_addr;
    logic              mem_rsp_valid;
    logic [WORD_W-1:0] mem_rsp_data;
    logic              desc_valid;
    logic [WORD_W-1:0] desc_src, desc_dst, desc_count, desc_ctrl;
    logic              xfer_done;
    logic [2:0]        walk_status;
    logic [PTR_W-1:0]  cur_desc_addr;

    always #5 clk = ~clk;

    dchain_walker #(.WORD_W(WORD_W), .PTR_W(PTR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_suspend(ctl_suspend),
        .ctl_resume(ctl_resume), .ctl_start_addr(ctl_start_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .desc_valid(desc_valid), .desc_src(desc_src), .desc_dst(desc_dst),
        .desc_count(desc_count), .desc_ctrl(desc_ctrl), .xfer_done(xfer_done),
        .walk_status(walk_status), .cur_desc_addr(cur_desc_addr)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [15:0] mem [0:127];
    int mem_lat = 0, eng_lat = 0, req_cnt = 0, cyc = 0;
    bit stall_en = 0, eng_hold = 0;

    logic [15:0] e_src [0:15], e_dst [0:15], e_cnt [0:15], e_ctl [0:15];
    logic [15:0] o_src [0:15], o_dst [0:15], o_cnt [0:15], o_ctl [0:15];
    int e_n = 0, obs_n = 0;

    // bench memory: 64 words low, 64 words with address bit 16 set
    function automatic int midx(input logic [31:0] a);
        return int'({a[16], a[5:0]});
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_desc(input logic [31:0] p, input logic [31:0] nxt,
                            input logic [15:0] s, input logic [15:0] d,
                            input logic [15:0] c, input logic [15:0] k);
        mem[midx(p)]     = nxt[15:0];
        mem[midx(p + 1)] = nxt[31:16];
        mem[midx(p + 2)] = s;
        mem[midx(p + 3)] = d;
        mem[midx(p + 4)] = c;
        mem[midx(p + 5)] = k;
    endtask

    task automatic expect_desc(input int i, input logic [15:0] s, input logic [15:0] d,
                               input logic [15:0] c, input logic [15:0] k);
        e_src[i] = s; e_dst[i] = d; e_cnt[i] = c; e_ctl[i] = k;
    endtask

    task automatic kick(input logic [31:0] a);
        @(negedge clk);
        ctl_start_addr = a;
        ctl_start = 1'b1;
        @(negedge clk);
        ctl_start = 1'b0;
    endtask

    task automatic pulse_resume();
        @(negedge clk);
        ctl_resume = 1'b1;
        @(negedge clk);
        ctl_resume = 1'b0;
    endtask

    task automatic wait_status(input logic [2:0] s, input int maxc, input string tag);
        int c = 0;
        while (walk_status !== s && c < maxc) begin
            @(negedge clk);
            c++;
        end
        check(walk_status === s, tag, walk_status, s);
    endtask

    task automatic compare_run(input string tag);
        check(obs_n == e_n, {tag, " descriptor count"}, obs_n, e_n);
        for (int i = 0; i < e_n && i < obs_n; i++) begin
            check(o_src[i] == e_src[i], {tag, " src"}, o_src[i], e_src[i]);
            check(o_dst[i] == e_dst[i], {tag, " dst"}, o_dst[i], e_dst[i]);
            check(o_cnt[i] == e_cnt[i], {tag, " count"}, o_cnt[i], e_cnt[i]);
            check(o_ctl[i] == e_ctl[i], {tag, " ctrl"}, o_ctl[i], e_ctl[i]);
        end
    endtask

    // memory responder: one word per accepted request, mem_lat+1 cycles later
    initial begin
        logic [31:0] raddr;
        logic [15:0] rdat;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        mem_req_ready = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            mem_req_ready = !(stall_en && (cyc % 3 == 1));
            if (rst_n && mem_req_valid && mem_req_ready) begin
                req_cnt++;
                raddr = mem_req_addr;
                rdat  = mem[midx(raddr)];
                repeat (mem_lat + 1) @(negedge clk);
                mem_rsp_data  = rdat;
                mem_rsp_valid = 1'b1;
            end
        end
    end

    // transfer engine model: logs each presented descriptor, then signals done
    initial begin
        xfer_done = 1'b0;
        forever begin
            @(negedge clk);
            if (xfer_done) begin
                xfer_done = 1'b0;
            end else if (desc_valid) begin
                if (obs_n < 16) begin
                    o_src[obs_n] = desc_src;
                    o_dst[obs_n] = desc_dst;
                    o_cnt[obs_n] = desc_count;
                    o_ctl[obs_n] = desc_ctrl;
                end
                obs_n++;
                repeat (eng_lat) @(negedge clk);
                while (eng_hold) @(negedge clk);
                xfer_done = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int base;
        logic [15:0] s;
        rst_n = 1'b0;
        ctl_start = 1'b0; ctl_suspend = 1'b0; ctl_resume = 1'b0; ctl_start_addr = '0;
        for (int i = 0; i < 128; i++) mem[i] = 16'hEEEE;
        repeat (3) @(negedge clk);
        check(walk_status == 3'd0, "R1 status in reset", walk_status, 0);
        check(!mem_req_valid && !desc_valid, "R1 outputs quiet in reset", {mem_req_valid, desc_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(walk_status == 3'd0, "R1 status after reset", walk_status, 0);

        // R2 R3 R4: sweep of chain length, memory latency and request stalls
        for (int n = 1; n <= 4; n++) begin
            for (int lat = 0; lat <= 2; lat++) begin
                for (int st = 0; st <= 1; st++) begin
                    s = 16'(n * 8 + lat * 2 + st);
                    mem_lat = lat; eng_lat = lat; stall_en = bit'(st);
                    for (int k = 0; k < n; k++) begin
                        put_desc(32'(8 * (k + 1)), (k == n - 1) ? 32'd0 : 32'(8 * (k + 2)),
                                 16'h1000 + s * 16'd32 + 16'(k), 16'h2000 + s * 16'd32 + 16'(k),
                                 16'(k + 1) + s, 16'(k) ^ s);
                        expect_desc(k, 16'h1000 + s * 16'd32 + 16'(k), 16'h2000 + s * 16'd32 + 16'(k),
                                    16'(k + 1) + s, 16'(k) ^ s);
                    end
                    e_n = n; obs_n = 0;
                    kick(32'd8);
                    wait_status(3'd4, 600, "R4 chain reaches done");
                    compare_run("R2 R3 sweep");
                    check(!desc_valid && !mem_req_valid, "R4 done is quiet", {desc_valid, mem_req_valid}, 0);
                end
            end
        end
        stall_en = 0; mem_lat = 1; eng_lat = 0;

        // R5: link into the upper half of the address space, decoy at the low alias
        put_desc(32'd8, 32'h0001_0010, 16'h0A01, 16'h0B01, 16'd3, 16'd1);
        put_desc(32'h0001_0010, 32'd0, 16'h0A02, 16'h0B02, 16'd4, 16'd2);
        put_desc(32'd16, 32'd0, 16'hBAD0, 16'hBAD1, 16'd9, 16'd9);
        expect_desc(0, 16'h0A01, 16'h0B01, 16'd3, 16'd1);
        expect_desc(1, 16'h0A02, 16'h0B02, 16'd4, 16'd2);
        e_n = 2; obs_n = 0;
        kick(32'd8);
        wait_status(3'd4, 200, "R5 wide chain done");
        compare_run("R5 wide pointer");

        // R6 R8 R9: suspend at a boundary, splice a sub-chain, resume
        put_desc(32'd8,  32'd16, 16'h0C00, 16'h0D00, 16'd1, 16'd0);
        put_desc(32'd16, 32'd24, 16'h0C01, 16'h0D01, 16'd2, 16'd1);
        put_desc(32'd24, 32'd0,  16'h0C02, 16'h0D02, 16'd3, 16'd2);
        obs_n = 0; eng_hold = 1;
        kick(32'd8);
        wait_status(3'd2, 100, "R3 first descriptor active");
        ctl_suspend = 1'b1;
        repeat (3) @(negedge clk);
        check(walk_status == 3'd2, "R6 suspend ignored mid-transfer", walk_status, 2);
        kick(32'h30);
        check(cur_desc_addr == 32'd8, "R2 start ignored while busy", cur_desc_addr, 8);
        eng_hold = 0;
        wait_status(3'd3, 20, "R6 boundary suspend");
        check(cur_desc_addr == 32'd8, "R6 pointer not advanced", cur_desc_addr, 8);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!mem_req_valid, "R6 no reads while suspended", mem_req_valid, 0);
        end
        pulse_resume();
        @(negedge clk);
        check(walk_status == 3'd3, "R8 resume ignored with suspend high", walk_status, 3);
        mem[8] = 16'd40; mem[9] = 16'd0;
        put_desc(32'd40, 32'd48, 16'h0E00, 16'h0F00, 16'd5, 16'd7);
        put_desc(32'd48, 32'd16, 16'h0E01, 16'h0F01, 16'd6, 16'd8);
        expect_desc(0, 16'h0C00, 16'h0D00, 16'd1, 16'd0);
        expect_desc(1, 16'h0E00, 16'h0F00, 16'd5, 16'd7);
        expect_desc(2, 16'h0E01, 16'h0F01, 16'd6, 16'd8);
        expect_desc(3, 16'h0C01, 16'h0D01, 16'd2, 16'd1);
        expect_desc(4, 16'h0C02, 16'h0D02, 16'd3, 16'd2);
        e_n = 5;
        ctl_suspend = 1'b0;
        base = req_cnt;
        pulse_resume();
        wait_status(3'd4, 400, "R9 spliced chain done");
        compare_run("R9 splice followed");
        check(req_cnt - base == 2 + 6 * 4, "R9 link-only re-read", req_cnt - base, 26);

        // R9: boundary suspend on the last descriptor, resume without a splice
        put_desc(32'd8, 32'd0, 16'h1111, 16'h2222, 16'd7, 16'd3);
        obs_n = 0; eng_hold = 1;
        kick(32'd8);
        wait_status(3'd2, 100, "R3 tail descriptor active");
        ctl_suspend = 1'b1;
        eng_hold = 0;
        wait_status(3'd3, 20, "R6 tail suspend");
        ctl_suspend = 1'b0;
        base = req_cnt;
        pulse_resume();
        wait_status(3'd4, 100, "R9 zero link ends chain");
        check(req_cnt - base == 2, "R9 zero link reads", req_cnt - base, 2);
        check(obs_n == 1, "R9 no repeat of finished descriptor", obs_n, 1);

        // R7 R8 R10: suspend during a fetch with a read in flight
        mem_lat = 6;
        put_desc(32'd8,  32'd16, 16'h3300, 16'h4400, 16'd9, 16'd4);
        put_desc(32'd16, 32'd0,  16'h3301, 16'h4401, 16'd8, 16'd5);
        obs_n = 0;
        base = req_cnt;
        kick(32'd8);
        do @(negedge clk); while (req_cnt - base < 3);
        @(negedge clk);
        ctl_suspend = 1'b1;
        @(negedge clk);
        check(walk_status == 3'd3, "R7 suspend during fetch", walk_status, 3);
        check(cur_desc_addr == 32'd8, "R7 pointer kept", cur_desc_addr, 8);
        check(!desc_valid, "R7 nothing presented", desc_valid, 0);
        ctl_suspend = 1'b0;
        pulse_resume();
        @(negedge clk);
        check(walk_status == 3'd3, "R8 resume refused with read outstanding", walk_status, 3);
        mem[10] = 16'h5A5A;
        expect_desc(0, 16'h5A5A, 16'h4400, 16'd9, 16'd4);
        expect_desc(1, 16'h3301, 16'h4401, 16'd8, 16'd5);
        e_n = 2;
        repeat (12) @(negedge clk);
        pulse_resume();
        wait_status(3'd4, 400, "R10 chain done after refetch");
        compare_run("R10 full re-read");
        check(obs_n == 2, "R7 dropped data not presented", obs_n, 2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule